// File: doc/BRIEF.md
# Sideband Channel Transaction Controller with Bounded Retry

This block carries out a single transaction on a display sideband (auxiliary) channel for a host. The host hands over a 4-bit transaction type, a 20-bit target address, a byte count from 1 to 16 and up to 16 bytes of write data. The controller then works through a fixed sequence:

- It waits for the channel to go quiet.
- It claims the channel and waits for the grant.
- It confirms that a sink is attached.
- For writes, it loads the write buffer.
- It runs one or more attempts. Each attempt is a reset pulse followed by a start pulse and a wait for completion.

The controller retries while the engine reports error bits. When the transaction ends, successfully or not, it releases the channel and reports exactly one outcome to the host.

The transaction engine beneath the block is abstract. The controller sees only request/start, pending, grant, busy, sink-present and error-status bits, plus a 16-byte transmit image and a 16-byte receive image. Every wait is bounded by a cycle count. Each count is derived from a clocks-per-microsecond parameter and a per-stage limit in microseconds. The stage limits are: channel idle 1000 µs, grant 1000 µs, completion 1000 µs, and back-off between attempts 400 µs. At most 32 attempts are made.

The state machine has the following states:

- **IDLE**: accepts a request (transition *accept*).
- **WAIT_FREE**: leaves on *free* or on *idle_timeout*.
- **CLAIM**: leaves on *granted* or on *grant_timeout*.
- **SINK**: leaves on *no_sink*, on *to_load* for a write, or on *to_reset* for a read.
- **LOAD**: moves to RST_ON.
- **RST_ON**: moves to RST_OFF.
- **RST_OFF**: goes to START on the *first_try*, or to BACKOFF on a *retry*.
- **BACKOFF**: leaves on *backoff_over*.
- **START**: moves to WAIT_DONE.
- **WAIT_DONE**: leaves on *completed* or on *done_timeout*.
- **CHECK**: leaves on *clean*, on *again*, or on *exhausted*.
- **FINISH**: returns to IDLE.

Top module: `auxch_txn_ctrl`

## Requirements
- R1: A transaction leaves WAIT_FREE only when both `eng_busy` and `eng_pending` are low. If that does not happen within IDLE_US·CLK_PER_US cycles, the result is an error with code 1 (busy), and `eng_claim` never rises.
- R2: `eng_claim` rises after the channel is free. If `eng_grant` is not seen within GRANT_US·CLK_PER_US cycles, the result is an error with code 1 (busy), and the claim is dropped.
- R3: If `eng_sink_present` is low once the grant arrives, the result is an error with code 2 (no device). In that case no `eng_wr_load` pulse and no `eng_start` pulse occur.
- R4: Bit 0 of the type selects the direction: 1 is a read, 0 is a write. A write gives exactly one `eng_wr_load` pulse before the first start. Read transactions give no `eng_wr_load` pulse. In `eng_wdata`, byte i is bits 8i+7..8i. Bytes at or above the count are zero.
- R5: During an attempt, `eng_len_m1` equals the count minus one (4 bits), `eng_type` equals the request type (4 bits), and `eng_addr` equals the request address (20 bits).
- R6: Each attempt pulses `eng_reset` for one cycle, then lowers it, then pulses `eng_start`. For the first attempt, `eng_start` comes 2 cycles after `eng_reset`. For later attempts it comes 2 + BACKOFF_US·CLK_PER_US cycles after `eng_reset`.
- R7: If `eng_pending` stays high for DONE_US·CLK_PER_US cycles after a start, the transaction ends at once as an error with code 4 (timeout).
- R8: An attempt succeeds when every bit of `eng_err` is zero after `eng_pending` falls; otherwise another attempt follows. After MAX_TRIES (32) failed attempts, the result is an error with code 3 (remote I/O), with exactly 32 start pulses.
- R9: After a successful read, bytes below the count of `rsp_rdata` equal the matching bytes of `eng_rdata`, and the higher bytes are zero. After a write or any failure, `rsp_rdata` is zero.
- R10: Every transaction ends with exactly one one-cycle pulse, either `rsp_done` (code 0) or `rsp_err` (nonzero code).
- R11: `eng_claim` is low whenever the outcome pulse is shown and afterwards. While a transaction is running, `req_ready` is low and `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transaction (taken when req_ready is high) |
| req_ready | output | 1 | Controller idle |
| req_type | input | 4 | Transaction type; bit 0 = read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count, 1..16 |
| req_wdata | input | 128 | Write bytes, byte i at bits 8i+7..8i |
| rsp_done | output | 1 | One-cycle success pulse |
| rsp_err | output | 1 | One-cycle failure pulse |
| rsp_code | output | 3 | 0 ok, 1 busy, 2 no device, 3 remote I/O, 4 timeout |
| rsp_rdata | output | 128 | Read bytes, masked to the count |
| eng_claim | output | 1 | Channel claimed |
| eng_grant | input | 1 | Claim acknowledged |
| eng_busy | input | 1 | Channel busy with another user |
| eng_pending | input | 1 | Engine request still in progress |
| eng_sink_present | input | 1 | Sink attached |
| eng_wr_load | output | 1 | Load transmit image |
| eng_wdata | output | 128 | Transmit image |
| eng_type | output | 4 | Transaction type field |
| eng_addr | output | 20 | Address field |
| eng_len_m1 | output | 4 | Count minus one |
| eng_reset | output | 1 | Per-attempt reset pulse |
| eng_start | output | 1 | Attempt start pulse |
| eng_err | input | 8 | Error status bits of the last attempt |
| eng_rdata | input | 128 | Receive image |

## Verification
A wrong state or transition shows up at the ports as a wrong outcome code, or as a pulse that appears or goes missing. Examples are a start after a missing sink, a second transmit load, or a claim that stays high after the outcome pulse. All of these are visible within one transaction. Faults in the attempt counter or the back-off timer show up as a wrong number of start pulses or a reset-to-start gap that is off by cycles. These become visible at the first retry, or by the 32nd attempt at the latest. A fault in the byte mask shows as nonzero high bytes in the transmit image or in the read result in the same transaction.

// File: rtl/auxch_pkg.sv
package auxch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_CLAIM,
        ST_SINK,
        ST_LOAD,
        ST_RST_ON,
        ST_RST_OFF,
        ST_BACKOFF,
        ST_START,
        ST_WAIT_DONE,
        ST_CHECK,
        ST_FINISH
    } state_e;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_BUSY    = 3'd1,
        RC_NODEV   = 3'd2,
        RC_REMOTE  = 3'd3,
        RC_TIMEOUT = 3'd4
    } rcode_e;

endpackage

// File: rtl/auxch_wait_timer.sv
module auxch_wait_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // limit is at least one cycle, so the last counted cycle is limit-1
    assign expired = (cnt_q >= (limit - 1'b1));

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/auxch_data_buf.sv
module auxch_data_buf #(
    parameter int NBYTES = 16,
    localparam int LEN_W = $clog2(NBYTES),
    localparam int DATA_W = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [DATA_W-1:0] wdata_raw,
    output logic [DATA_W-1:0] wdata_masked,
    input  logic              clear,
    input  logic              capture,
    input  logic [DATA_W-1:0] rdata_raw,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] rdata_masked;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic keep;
        assign keep = (LEN_W'(b) <= len_m1);
        assign wdata_masked[8*b +: 8] = keep ? wdata_raw[8*b +: 8] : 8'h00;
        assign rdata_masked[8*b +: 8] = keep ? rdata_raw[8*b +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= rdata_masked;
        end
    end

endmodule

// File: rtl/auxch_txn_ctrl.sv
module auxch_txn_ctrl
    import auxch_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int IDLE_US    = 1000,
    parameter int GRANT_US   = 1000,
    parameter int DONE_US    = 1000,
    parameter int BACKOFF_US = 400,
    parameter int MAX_TRIES  = 32,
    parameter int ADDR_W     = 20,
    parameter int TYPE_W     = 4,
    parameter int ERR_W      = 8,
    parameter int MAX_BYTES  = 16,
    localparam int LEN_W     = $clog2(MAX_BYTES),
    localparam int CNT_IN_W  = $clog2(MAX_BYTES + 1),
    localparam int DATA_W    = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_IN_W-1:0] req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [2:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              eng_claim,
    input  logic              eng_grant,
    input  logic              eng_busy,
    input  logic              eng_pending,
    input  logic              eng_sink_present,
    output logic              eng_wr_load,
    output logic [DATA_W-1:0] eng_wdata,
    output logic [TYPE_W-1:0] eng_type,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [LEN_W-1:0]  eng_len_m1,
    output logic              eng_reset,
    output logic              eng_start,
    input  logic [ERR_W-1:0]  eng_err,
    input  logic [DATA_W-1:0] eng_rdata
);
    localparam int IDLE_CYC  = IDLE_US * CLK_PER_US;
    localparam int GRANT_CYC = GRANT_US * CLK_PER_US;
    localparam int DONE_CYC  = DONE_US * CLK_PER_US;
    localparam int BACK_CYC  = BACKOFF_US * CLK_PER_US;
    localparam int TMR_W     = $clog2(IDLE_CYC + GRANT_CYC + DONE_CYC + BACK_CYC + 2);
    localparam int TRY_W     = $clog2(MAX_TRIES + 1);

    state_e state_q, state_d;
    rcode_e rc_q, rc_d;

    logic [TYPE_W-1:0] type_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  lenm1_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TRY_W-1:0]  tries_q;

    logic [TMR_W-1:0] tmr_limit;
    logic             tmo;
    logic             accept;
    logic             attempt_bad;

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign attempt_bad = (eng_err != '0);

    // request latch: fields stay fixed for the whole transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q  <= '0;
            addr_q  <= '0;
            lenm1_q <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            type_q  <= req_type;
            addr_q  <= req_addr;
            lenm1_q <= LEN_W'(req_len - 1'b1);
            wdata_q <= req_wdata;
        end
    end

    // attempt counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            tries_q <= '0;
        end else if (state_q == ST_CHECK && attempt_bad) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // per-state wait bound
    always_comb begin
        unique case (state_q)
            ST_WAIT_FREE: tmr_limit = TMR_W'(IDLE_CYC);
            ST_CLAIM:     tmr_limit = TMR_W'(GRANT_CYC);
            ST_BACKOFF:   tmr_limit = TMR_W'(BACK_CYC);
            ST_WAIT_DONE: tmr_limit = TMR_W'(DONE_CYC);
            default:      tmr_limit = TMR_W'(1);
        endcase
    end

    auxch_wait_timer #(.CNT_W(TMR_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .limit   (tmr_limit),
        .expired (tmo)
    );

    auxch_data_buf #(.NBYTES(MAX_BYTES)) i_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .len_m1       (lenm1_q),
        .wdata_raw    (wdata_q),
        .wdata_masked (eng_wdata),
        .clear        (accept),
        .capture      (state_q == ST_CHECK && !attempt_bad && type_q[0]),
        .rdata_raw    (eng_rdata),
        .rdata_q      (rsp_rdata)
    );

    // next state and outcome code
    always_comb begin
        state_d = state_q;
        rc_d    = rc_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_WAIT_FREE;
            ST_WAIT_FREE: begin
                if (!eng_busy && !eng_pending) begin
                    state_d = ST_CLAIM;
                end else if (tmo) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_BUSY;
                end
            end
            ST_CLAIM: begin
                if (eng_grant) begin
                    state_d = ST_SINK;
                end else if (tmo) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_BUSY;
                end
            end
            ST_SINK: begin
                if (!eng_sink_present) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_NODEV;
                end else if (!type_q[0]) begin
                    state_d = ST_LOAD;
                end else begin
                    state_d = ST_RST_ON;
                end
            end
            ST_LOAD:    state_d = ST_RST_ON;
            ST_RST_ON:  state_d = ST_RST_OFF;
            ST_RST_OFF: state_d = (tries_q != '0) ? ST_BACKOFF : ST_START;
            ST_BACKOFF: if (tmo) state_d = ST_START;
            ST_START:   state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: begin
                if (!eng_pending) begin
                    state_d = ST_CHECK;
                end else if (tmo) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_TIMEOUT;
                end
            end
            ST_CHECK: begin
                if (!attempt_bad) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_OK;
                end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
                    state_d = ST_FINISH;
                    rc_d    = RC_REMOTE;
                end else begin
                    state_d = ST_RST_ON;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rc_q    <= RC_OK;
        end else begin
            state_q <= state_d;
            rc_q    <= rc_d;
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        eng_claim   = 1'b0;
        eng_wr_load = 1'b0;
        eng_reset   = 1'b0;
        eng_start   = 1'b0;
        rsp_done    = 1'b0;
        rsp_err     = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_WAIT_FREE: ;
            ST_CLAIM, ST_SINK, ST_RST_OFF, ST_BACKOFF, ST_WAIT_DONE, ST_CHECK:
                eng_claim = 1'b1;
            ST_LOAD: begin
                eng_claim   = 1'b1;
                eng_wr_load = 1'b1;
            end
            ST_RST_ON: begin
                eng_claim = 1'b1;
                eng_reset = 1'b1;
            end
            ST_START: begin
                eng_claim = 1'b1;
                eng_start = 1'b1;
            end
            ST_FINISH: begin
                rsp_done = (rc_q == RC_OK);
                rsp_err  = (rc_q != RC_OK);
            end
            default: ;
        endcase
    end

    assign rsp_code   = rc_q;
    assign eng_type   = type_q;
    assign eng_addr   = addr_q;
    assign eng_len_m1 = lenm1_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_err) |=> !(rsp_done || rsp_err)); // R10
    AST_DONE_IS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_code == 3'd0)); // R10
    AST_CLAIM_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_claim) |-> (rsp_done || rsp_err)); // R11
    AST_START_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_claim && $past(eng_claim))); // R6
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |=> (!eng_reset && !eng_start)); // R6
    AST_LOAD_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr_load |-> !eng_type[0]); // R4
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= TRY_W'(MAX_TRIES)); // R8
    AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !eng_claim); // R11

endmodule

// File: tb/test_auxch_txn_ctrl.sv
module test_auxch_txn_ctrl;
    localparam int CPU   = 2;
    localparam int BACK  = 400 * CPU;
    localparam int TRIES = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_type = '0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_len = 5'd1;
    logic [127:0] req_wdata = '0;
    logic         rsp_done, rsp_err;
    logic [2:0]   rsp_code;
    logic [127:0] rsp_rdata;
    logic         eng_claim, eng_grant, eng_busy, eng_pending, eng_sink_present;
    logic         eng_wr_load, eng_reset, eng_start;
    logic [127:0] eng_wdata, eng_rdata;
    logic [3:0]   eng_type, eng_len_m1;
    logic [19:0]  eng_addr;
    logic [7:0]   eng_err;

    // engine model knobs, driven from tasks
    logic m_busy = 1'b0, m_no_grant = 1'b0, m_no_sink = 1'b0, m_hang = 1'b0, m_clr = 1'b0;
    int   m_fail = 0;
    int   m_lat = 1;
    logic [127:0] m_rdata = '0;

    // engine model observations
    logic pend;
    int   lat_cnt, starts, loads, gap, first_gap, retry_gap;
    logic claim_while_busy;
    logic [127:0] seen_wdata;
    logic [3:0]   seen_len, seen_type;
    logic [19:0]  seen_addr;

    assign eng_busy         = m_busy;
    assign eng_pending      = pend;
    assign eng_sink_present = !m_no_sink;
    assign eng_rdata        = m_rdata;

    always @(posedge clk) begin
        if (!rst_n || m_clr) begin
            eng_grant <= 1'b0; pend <= 1'b0; eng_err <= '0; lat_cnt <= 0;
            starts <= 0; loads <= 0; gap <= 0; first_gap <= -1; retry_gap <= -1;
            claim_while_busy <= 1'b0; seen_wdata <= '0;
            seen_len <= '0; seen_type <= '0; seen_addr <= '0;
        end else begin
            eng_grant <= eng_claim && !m_no_grant;
            if (eng_claim && m_busy) claim_while_busy <= 1'b1;
            if (eng_wr_load) begin
                loads <= loads + 1;
                seen_wdata <= eng_wdata;
            end
            if (eng_reset) gap <= 1; else gap <= gap + 1;
            if (eng_start) begin
                if (starts == 0) first_gap <= gap; else retry_gap <= gap;
                starts <= starts + 1;
                pend <= 1'b1; lat_cnt <= m_lat; eng_err <= '0;
                seen_len <= eng_len_m1; seen_type <= eng_type; seen_addr <= eng_addr;
            end else if (pend && !m_hang) begin
                if (lat_cnt <= 1) begin
                    pend <= 1'b0;
                    eng_err <= (starts <= m_fail) ? 8'h04 : 8'h00;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    auxch_txn_ctrl #(.CLK_PER_US(CPU)) i_auxch_txn_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .eng_claim(eng_claim), .eng_grant(eng_grant), .eng_busy(eng_busy),
        .eng_pending(eng_pending), .eng_sink_present(eng_sink_present),
        .eng_wr_load(eng_wr_load), .eng_wdata(eng_wdata), .eng_type(eng_type),
        .eng_addr(eng_addr), .eng_len_m1(eng_len_m1), .eng_reset(eng_reset),
        .eng_start(eng_start), .eng_err(eng_err), .eng_rdata(eng_rdata)
    );

    int n_chk = 0, n_bad = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mask_bytes(input logic [127:0] d, input int len);
        logic [127:0] r = '0;
        for (int b = 0; b < 16; b++) if (b < len) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    // outcome of the last transaction
    logic         got_done, got_err, pulse_twice;
    logic [2:0]   got_code;
    logic [127:0] got_rdata;
    int           got_cycles;

    task automatic clear_model();
        @(negedge clk); m_clr = 1'b1;
        @(negedge clk); m_clr = 1'b0;
    endtask

    task automatic run_txn(input logic [3:0] t, input logic [19:0] a, input int len,
                           input logic [127:0] wd, input int busy_cyc, input logic poke);
        clear_model();
        if (busy_cyc != 0) m_busy = 1'b1;
        req_type = t; req_addr = a; req_len = 5'(len); req_wdata = wd; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        got_done = 0; got_err = 0; pulse_twice = 0; got_cycles = 0;
        while (!(rsp_done || rsp_err) && got_cycles < 40000) begin
            @(negedge clk); got_cycles++;
            if (busy_cyc > 0 && got_cycles == busy_cyc) m_busy = 1'b0;
            if (poke && got_cycles == 3) begin
                req_valid = 1'b1; req_type = ~t; req_addr = ~a;
            end else begin
                req_valid = 1'b0;
            end
        end
        got_done = rsp_done; got_err = rsp_err; got_code = rsp_code; got_rdata = rsp_rdata;
        @(negedge clk);
        if (rsp_done || rsp_err) pulse_twice = 1;
        m_busy = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !rsp_err && !eng_claim && rsp_rdata == 0, "R11 reset state",
            {req_ready, rsp_done, rsp_err, eng_claim}, 4'b1000);

        // directed read, 3 bytes, no retries (R4 R5 R6 R9 R10)
        m_rdata = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F; m_fail = 0; m_lat = 3;
        run_txn(4'h9, 20'h00202, 3, '1, 0, 0);
        chk(got_done && !got_err && got_code == 0, "R10 read ok", got_code, 0);
        chk(!pulse_twice, "R10 single pulse", pulse_twice, 0);
        chk(got_rdata == mask_bytes(m_rdata, 3), "R9 read mask", got_rdata, mask_bytes(m_rdata, 3));
        chk(loads == 0, "R4 read no load", loads, 0);
        chk(seen_len == 4'd2 && seen_type == 4'h9 && seen_addr == 20'h00202, "R5 fields",
            {seen_len, seen_type, seen_addr}, {4'd2, 4'h9, 20'h00202});
        chk(first_gap == 2, "R6 first gap", first_gap, 2);
        chk(!eng_claim, "R11 released", eng_claim, 0);

        // full 16-byte write with two retries
        m_fail = 2; m_lat = 2;
        run_txn(4'h8, 20'hFFFFF, 16, 128'h0123456789ABCDEF_FEDCBA9876543210, 0, 0);
        chk(got_done && got_code == 0, "R8 success after retries", got_code, 0);
        chk(starts == 3, "R8 attempt count", starts, 3);
        chk(retry_gap == 2 + BACK, "R6 backoff gap", retry_gap, 2 + BACK);
        chk(loads == 1 && seen_wdata == 128'h0123456789ABCDEF_FEDCBA9876543210, "R4 write image",
            seen_wdata, 128'h0123456789ABCDEF_FEDCBA9876543210);
        chk(got_rdata == 0, "R9 write leaves zero", got_rdata, 0);

        // channel busy for a while, then free (R1)
        m_fail = 0;
        run_txn(4'h0, 20'h1, 1, 128'hAB, 50, 0);
        chk(got_done && !claim_while_busy, "R1 wait for idle", {got_done, claim_while_busy}, 2'b10);
        chk(seen_wdata == 128'hAB, "R4 one byte write", seen_wdata, 128'hAB);

        // channel never free (R1)
        run_txn(4'h1, 20'h2, 4, '0, -1, 0);
        chk(got_err && got_code == 1, "R1 idle timeout", got_code, 1);
        chk(!claim_while_busy && starts == 0, "R1 no claim", {claim_while_busy, 8'(starts)}, 0);

        // no grant (R2)
        m_no_grant = 1'b1;
        run_txn(4'h1, 20'h3, 4, '0, 0, 0);
        m_no_grant = 1'b0;
        chk(got_err && got_code == 1, "R2 grant timeout", got_code, 1);
        chk(!eng_claim && starts == 0, "R2 claim dropped", {eng_claim, 8'(starts)}, 0);

        // no sink (R3)
        m_no_sink = 1'b1;
        run_txn(4'h0, 20'h4, 8, '1, 0, 0);
        m_no_sink = 1'b0;
        chk(got_err && got_code == 2, "R3 no device", got_code, 2);
        chk(loads == 0 && starts == 0, "R3 no transfer", {8'(loads), 8'(starts)}, 0);

        // engine hangs (R7)
        m_hang = 1'b1;
        run_txn(4'h1, 20'h5, 2, '0, 0, 0);
        m_hang = 1'b0;
        chk(got_err && got_code == 4, "R7 completion timeout", got_code, 4);
        chk(starts == 1 && got_rdata == 0, "R7 single attempt", starts, 1);
        clear_model();

        // every attempt fails (R8)
        m_fail = 1000; m_lat = 1;
        run_txn(4'h1, 20'h6, 5, '0, 0, 0);
        chk(got_err && got_code == 3, "R8 remote error", got_code, 3);
        chk(starts == TRIES, "R8 32 attempts", starts, TRIES);
        chk(got_rdata == 0, "R9 failed read zero", got_rdata, 0);

        // new request while running is ignored (R11)
        m_fail = 0; m_lat = 6;
        run_txn(4'h1, 20'h7, 2, '0, 0, 1);
        repeat (10) @(negedge clk);
        chk(got_done && starts == 1 && seen_addr == 20'h7, "R11 request ignored while running",
            {8'(starts), seen_addr}, {8'd1, 20'h7});
        chk(req_ready && !eng_claim, "R11 idle after", {req_ready, eng_claim}, 2'b10);

        // random traffic
        for (int i = 0; i < 20; i++) begin
            logic [3:0]   t  = 4'($urandom);
            logic [19:0]  a  = 20'($urandom);
            int           ln = 1 + ($urandom % 16);
            logic [127:0] wd = {$urandom, $urandom, $urandom, $urandom};
            m_rdata = {$urandom, $urandom, $urandom, $urandom};
            m_fail = $urandom % 3; m_lat = 1 + ($urandom % 5);
            run_txn(t, a, ln, wd, 0, 0);
            chk(got_done && got_code == 0 && !pulse_twice, "R10 random outcome", got_code, 0);
            chk(starts == m_fail + 1, "R8 random attempts", starts, m_fail + 1);
            chk(seen_len == 4'(ln - 1) && seen_type == t && seen_addr == a, "R5 random fields",
                {seen_len, seen_type, seen_addr}, {4'(ln - 1), t, a});
            if (t[0]) begin
                chk(loads == 0 && got_rdata == mask_bytes(m_rdata, ln), "R9 random read",
                    got_rdata, mask_bytes(m_rdata, ln));
            end else begin
                chk(loads == 1 && seen_wdata == mask_bytes(wd, ln), "R4 random write",
                    seen_wdata, mask_bytes(wd, ln));
            end
            if (m_fail > 0) chk(retry_gap == 2 + BACK, "R6 random gap", retry_gap, 2 + BACK);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule